// File: doc/BRIEF.md
# FPGA Slave-SPI Configuration Sequencer

This block acts as the controlling side of a slave-mode SPI link and writes a complete configuration image into the SRAM of a target FPGA. A single start pulse launches the whole sequence. First the block pulls the target's active-low reset and chip select low together and holds them there. It then releases reset and confirms that the target's configuration-done line has dropped. With chip select still low, it waits out the target's internal housekeeping interval, and after that it raises chip select for a short gap.

Next it lowers chip select again and shifts the image bytes out from a byte-wide valid/ready stream. When the byte flagged as last has gone out, it raises chip select and checks that configuration-done is now high. On success it sends whole zero bytes so that the target receives at least the required number of trailing activation clocks.

Status is reported on three outputs: a busy flag, a done flag and a 2-bit error code. Both flags stay latched until the next start. A request marked as partial reconfiguration is turned away at once, and the target pins do not move. The serial clock rate, the reset hold time, the housekeeping time and the number of trailing clocks are all set by parameters. Time values are converted into cycle counts from the system clock frequency.

Top module: `cfg_loader`

## Requirements
- R1: A non-partial start drives `tgt_rst_n_o` and `tgt_cs_n_o` low in the same cycle. Reset then stays low for at least RST_US microseconds of system clock, and chip select is low in every cycle in which reset is low.
- R2: Once reset has been released and the synchronized configuration-done input has settled, the block samples it. If it reads high, the run aborts with error code 1 (reset failed), and no serial clock edge is produced.
- R3: After reset is released, chip select stays low and reset high for at least HK_US microseconds. Chip select is then raised before the first image byte is clocked.
- R4: Bytes are sent MSB first in SPI mode 0. The serial clock idles low, and the target samples on the rising edge. `tgt_mosi_o` changes only while the serial clock is low, and it is valid before the first rising edge of each byte.
- R5: Each half period of the serial clock lasts SCK_HALF system clocks. A parameter set that gives a serial clock outside 1 MHz to 25 MHz, or a reset hold under 1 us, stops elaboration.
- R6: `s_ready_o` is high only while the block is streaming the image with chip select low and the shifter empty. A byte is taken on a cycle with both valid and ready high. Gaps in valid are tolerated, and the byte with `s_last_i` set ends the stream.
- R7: After the last image byte, if the synchronized configuration-done input reads low, the run ends with error code 2 (not done), and no activation clocks are sent.
- R8: After a successful load, the block sends ceil(ACT_CLKS/8) zero bytes with chip select low, which is 56 clocks by default. It then ends with `done_o` = 1 and error code 0.
- R9: A start with `partial_i` high sets error code 3 (unsupported) on the next cycle. `busy_o` stays low, and reset and chip select stay high.
- R10: `busy_o` goes high in the cycle after an accepted start and stays high until the run ends. Start pulses that arrive while busy are ignored.
- R11: The error code and `done_o` keep their values until the next start, which clears both. Error code 0 means no error.
- R12: Whenever the block is idle, gapping or checking configuration-done, chip select is high and the serial clock is low. After every run, reset, chip select and clock return to high, high and low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| partial_i | input | 1 | Request is a partial reconfiguration (rejected) |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Image byte is the final one |
| s_ready_o | output | 1 | Block takes the byte this cycle |
| tgt_rst_n_o | output | 1 | Target reset, active low |
| tgt_cs_n_o | output | 1 | Target chip select, active low |
| tgt_sck_o | output | 1 | Serial clock to target |
| tgt_mosi_o | output | 1 | Serial data to target |
| tgt_done_i | input | 1 | Target configuration-done (asynchronous) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run succeeded |
| err_o | output | 2 | 0 none, 1 reset failed, 2 not done, 3 unsupported |

## Verification
The sequencer runs against a target model whose done line can be held high throughout, raised once every image byte has arrived, or never raised. Together these separate a clean load (R8), a failed reset (R2) and a missing done (R7). Image lengths of one to five bytes with different bit patterns show MSB-first order and mode-0 timing (R4). Stall gaps of zero, one and three cycles between bytes exercise the ready handshake (R6). A partial request, and a second start issued in the middle of a run, show that rejected or ignored requests leave the pins and the outcome unchanged (R9, R10).

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_RST_CHK,
    ST_HOUSEKEEP,
    ST_CS_GAP,
    ST_STREAM,
    ST_DONE_CHK,
    ST_ACTIVATE
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_RESET   = 2'd1,
    ERR_NODONE  = 2'd2,
    ERR_PARTIAL = 2'd3
  } seq_err_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) ff_q <= '0;
        else     ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff_q <= '0;
        else     ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_spi_tx.sv
module cfg_spi_tx #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       active_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [DW-1:0] DIV_END = DW'(SCK_HALF - 1);

  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] div_q;
  logic          act_q;
  logic          sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      bit_q <= '0;
      div_q <= '0;
      act_q <= 1'b0;
      sck_q <= 1'b0;
    end else if (load_i && !act_q) begin
      sh_q  <= byte_i;
      bit_q <= '0;
      div_q <= '0;
      act_q <= 1'b1;
      sck_q <= 1'b0;
    end else if (act_q) begin
      if (div_q == DIV_END) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            act_q <= 1'b0;
            sh_q  <= '0;
          end else begin
            sh_q  <= {sh_q[6:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign active_o = act_q;
  assign sck_o    = sck_q;
  assign mosi_o   = sh_q[7];
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SCK_HALF    = 2,
  parameter int RST_US      = 1,
  parameter int HK_US       = 1200,
  parameter int ACT_CLKS    = 49,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  output logic       tgt_rst_n_o,
  output logic       tgt_cs_n_o,
  output logic       tgt_sck_o,
  output logic       tgt_mosi_o,
  input  logic       tgt_done_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] err_o
);
  localparam int CYC_US    = CLK_HZ / 1_000_000;
  localparam int RST_CYC   = CYC_US * RST_US;
  localparam int HK_CYC    = CYC_US * HK_US;
  localparam int GAP_CYC   = 2 * SCK_HALF;
  localparam int CHK_CYC   = SYNC_STAGES + 1;
  localparam int SCK_HZ    = CLK_HZ / (2 * SCK_HALF);
  localparam int ACT_BYTES = (ACT_CLKS + 7) / 8;
  localparam int TW        = $clog2(RST_CYC + HK_CYC + GAP_CYC + CHK_CYC + 1);
  localparam int ABW       = $clog2(ACT_BYTES + 1);

  generate
    if (SCK_HZ < 1_000_000 || SCK_HZ > 25_000_000) begin : g_bad_sck
      $error("cfg_loader: serial clock rate out of 1..25 MHz");
    end
    if (RST_US < 1 || CYC_US < 1) begin : g_bad_rst
      $error("cfg_loader: reset hold or clock frequency too small");
    end
  endgenerate

  seq_state_t st_q, st_d;
  seq_err_t   err_q, err_val;
  logic       set_err, set_done;
  logic       tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic       tx_load, tx_active, tx_sck, tx_mosi;
  logic [7:0] tx_byte;
  logic       done_s;
  logic       last_q;
  logic [ABW-1:0] act_left_q;
  logic       busy_q, done_q, rst_n_q, cs_n_q;
  logic       ready;

  cfg_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk), .rst (rst), .d_i (tgt_done_i), .q_o (done_s)
  );

  cfg_timer #(.W(TW)) i_timer (
    .clk (clk), .rst (rst), .load_i (tmr_load), .val_i (tmr_val), .zero_o (tmr_zero)
  );

  cfg_spi_tx #(.SCK_HALF(SCK_HALF)) i_tx (
    .clk (clk), .rst (rst), .load_i (tx_load), .byte_i (tx_byte),
    .active_o (tx_active), .sck_o (tx_sck), .mosi_o (tx_mosi)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tx_load  = 1'b0;
    tx_byte  = s_data_i;
    set_err  = 1'b0;
    err_val  = ERR_NONE;
    set_done = 1'b0;
    ready    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (partial_i) begin
            set_err = 1'b1;
            err_val = ERR_PARTIAL;
          end else begin
            st_d     = ST_RST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = TW'(RST_CYC);
          end
        end
      end
      ST_RST_HOLD: begin
        if (tmr_zero) begin
          st_d     = ST_RST_CHK;
          tmr_load = 1'b1;
          tmr_val  = TW'(CHK_CYC);
        end
      end
      ST_RST_CHK: begin
        if (tmr_zero) begin
          if (done_s) begin
            st_d    = ST_IDLE;
            set_err = 1'b1;
            err_val = ERR_RESET;
          end else begin
            st_d     = ST_HOUSEKEEP;
            tmr_load = 1'b1;
            tmr_val  = TW'(HK_CYC);
          end
        end
      end
      ST_HOUSEKEEP: begin
        if (tmr_zero) begin
          st_d     = ST_CS_GAP;
          tmr_load = 1'b1;
          tmr_val  = TW'(GAP_CYC);
        end
      end
      ST_CS_GAP: begin
        if (tmr_zero) st_d = ST_STREAM;
      end
      ST_STREAM: begin
        ready   = !tx_active && !last_q;
        tx_load = s_valid_i && ready;
        if (last_q && !tx_active) begin
          st_d     = ST_DONE_CHK;
          tmr_load = 1'b1;
          tmr_val  = TW'(CHK_CYC);
        end
      end
      ST_DONE_CHK: begin
        if (tmr_zero) begin
          if (done_s) begin
            st_d = ST_ACTIVATE;
          end else begin
            st_d    = ST_IDLE;
            set_err = 1'b1;
            err_val = ERR_NODONE;
          end
        end
      end
      ST_ACTIVATE: begin
        tx_byte = 8'h00;
        if (!tx_active) begin
          if (act_left_q == '0) begin
            st_d     = ST_IDLE;
            set_done = 1'b1;
          end else begin
            tx_load = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      err_q      <= ERR_NONE;
      done_q     <= 1'b0;
      busy_q     <= 1'b0;
      rst_n_q    <= 1'b1;
      cs_n_q     <= 1'b1;
      last_q     <= 1'b0;
      act_left_q <= '0;
    end else begin
      st_q    <= st_d;
      busy_q  <= (st_d != ST_IDLE);
      rst_n_q <= (st_d != ST_RST_HOLD);
      cs_n_q  <= !(st_d inside {ST_RST_HOLD, ST_RST_CHK, ST_HOUSEKEEP,
                                ST_STREAM, ST_ACTIVATE});
      if (st_q == ST_IDLE && start_i) begin
        err_q  <= set_err ? err_val : ERR_NONE;
        done_q <= 1'b0;
      end else if (set_err) begin
        err_q  <= err_val;
      end else if (set_done) begin
        done_q <= 1'b1;
      end
      if (st_q != ST_STREAM)            last_q <= 1'b0;
      else if (tx_load && s_last_i)     last_q <= 1'b1;
      if (st_q != ST_ACTIVATE)          act_left_q <= ABW'(ACT_BYTES);
      else if (tx_load)                 act_left_q <= act_left_q - 1'b1;
    end
  end

  assign s_ready_o   = ready;
  assign tgt_rst_n_o = rst_n_q;
  assign tgt_cs_n_o  = cs_n_q;
  assign tgt_sck_o   = tx_sck;
  assign tgt_mosi_o  = tx_mosi;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       partial_i,
  input logic       s_ready_o,
  input logic       tgt_rst_n_o,
  input logic       tgt_cs_n_o,
  input logic       tgt_sck_o,
  input logic       tgt_mosi_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] err_o
);
  assert_rst_cs_low_R1: assert property (@(posedge clk) disable iff (rst)
    !tgt_rst_n_o |-> !tgt_cs_n_o);

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (rst)
    tgt_sck_o |-> $stable(tgt_mosi_o));

  assert_ready_window_R6: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> (busy_o && !tgt_cs_n_o && tgt_rst_n_o));

  assert_partial_reject_R9: assert property (@(posedge clk) disable iff (rst)
    (start_i && partial_i && !busy_o) |=>
      (err_o == 2'd3 && !busy_o && tgt_rst_n_o && tgt_cs_n_o));

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (start_i && !partial_i && !busy_o) |=> (busy_o && err_o == 2'd0 && !done_o));

  assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (err_o != 2'd0) |-> (!busy_o && !done_o));

  assert_done_clean_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (err_o == 2'd0 && !busy_o));

  assert_sck_idle_R12: assert property (@(posedge clk) disable iff (rst)
    tgt_cs_n_o |-> !tgt_sck_o);
endmodule

bind cfg_loader cfg_loader_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .partial_i   (partial_i),
  .s_ready_o   (s_ready_o),
  .tgt_rst_n_o (tgt_rst_n_o),
  .tgt_cs_n_o  (tgt_cs_n_o),
  .tgt_sck_o   (tgt_sck_o),
  .tgt_mosi_o  (tgt_mosi_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
  localparam int CLK_HZ   = 50_000_000;
  localparam int SCK_HALF = 2;
  localparam int RST_US   = 1;
  localparam int HK_US    = 4;
  localparam int RST_CYC  = RST_US * (CLK_HZ / 1_000_000);
  localparam int HK_CYC   = HK_US * (CLK_HZ / 1_000_000);
  localparam int ACT_BITS = 56;

  typedef struct packed {
    logic       partial;
    logic       stuck;
    logic       good;
    logic [3:0] n;
    logic [7:0] base;
    logic [3:0] stall;
    logic       restart;
    logic [1:0] xerr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 4'd4, 8'hA5, 4'd0, 1'b0, 2'd0},
    '{1'b0, 1'b0, 1'b1, 4'd1, 8'h3C, 4'd3, 1'b1, 2'd0},
    '{1'b0, 1'b0, 1'b0, 4'd3, 8'hF0, 4'd0, 1'b0, 2'd2},
    '{1'b0, 1'b1, 1'b0, 4'd2, 8'h11, 4'd0, 1'b0, 2'd1},
    '{1'b1, 1'b0, 1'b1, 4'd2, 8'h22, 4'd0, 1'b0, 2'd3},
    '{1'b0, 1'b0, 1'b1, 4'd5, 8'h81, 4'd1, 1'b0, 2'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       partial = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       tgt_rst_n, tgt_cs_n, tgt_sck, tgt_mosi;
  logic       tgt_done;
  logic       busy, done;
  logic [1:0] err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // target model state
  logic       cur_stuck = 1'b0;
  logic       cur_good = 1'b0;
  int         cur_n = 0;
  int         bits_base = 0;
  int         bits_total = 0;
  logic [7:0] sr = '0;
  logic [7:0] rx [64];
  int         rst_low = 0, rst_cs_bad = 0, hk_cnt = 0, ready_bad = 0;
  int         hi_run = 0, hi_pulses = 0, hi_bad = 0, accepted = 0;
  logic       hs = 1'b0;

  always #10 clk = ~clk;

  assign tgt_done = cur_stuck ? 1'b1 :
                    (cur_good && (bits_total - bits_base) >= 8 * cur_n);

  cfg_loader #(
    .CLK_HZ(CLK_HZ), .SCK_HALF(SCK_HALF), .RST_US(RST_US), .HK_US(HK_US),
    .ACT_CLKS(49), .SYNC_STAGES(2)
  ) i_cfg_loader (
    .clk(clk), .rst(rst), .start_i(start), .partial_i(partial),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
    .tgt_rst_n_o(tgt_rst_n), .tgt_cs_n_o(tgt_cs_n), .tgt_sck_o(tgt_sck),
    .tgt_mosi_o(tgt_mosi), .tgt_done_i(tgt_done),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  always @(posedge tgt_sck) begin
    if (!tgt_cs_n) begin
      sr = {sr[6:0], tgt_mosi};
      bits_total = bits_total + 1;
      if (bits_total % 8 == 0) rx[(bits_total / 8 - 1) % 64] = sr;
    end
  end

  always @(posedge clk) begin
    hs <= s_valid && s_ready;
    if (s_valid && s_ready) accepted <= accepted + 1;
    if (!rst) begin
      if (!tgt_rst_n) rst_low <= rst_low + 1;
      if (!tgt_rst_n && tgt_cs_n) rst_cs_bad <= rst_cs_bad + 1;
      if (tgt_rst_n && !tgt_cs_n && bits_total == bits_base) hk_cnt <= hk_cnt + 1;
      if (s_ready && tgt_cs_n) ready_bad <= ready_bad + 1;
    end
    if (tgt_sck) begin
      hi_run <= hi_run + 1;
    end else if (hi_run != 0) begin
      hi_pulses <= hi_pulses + 1;
      if (hi_run != SCK_HALF) hi_bad <= hi_bad + 1;
      hi_run <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string err_req(input logic [1:0] e);
    case (e)
      2'd1:    return "R2";
      2'd2:    return "R7";
      2'd3:    return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic run_case(input vec_t v);
    int rst0, bad0, hk0, hib0, hip0, acc0, rb0;
    int idx, stall_left;
    bit seen_busy, timed_out;
    int exp_bits;
    rst0 = rst_low; bad0 = rst_cs_bad; hk0 = hk_cnt; hib0 = hi_bad;
    hip0 = hi_pulses; acc0 = accepted; rb0 = ready_bad;
    @(negedge clk);
    bits_base = bits_total;
    cur_stuck = v.stuck; cur_good = v.good; cur_n = int'(v.n);
    start = 1'b1; partial = v.partial;
    @(negedge clk);
    start = 1'b0; partial = 1'b0;
    idx = 0; stall_left = 0; seen_busy = 1'b0; timed_out = 1'b1;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (busy) seen_busy = 1'b1;
      if (hs) begin idx++; stall_left = int'(v.stall); end
      if (v.restart && c == 100) begin start = 1'b1; partial = 1'b1; end
      else begin start = 1'b0; partial = 1'b0; end
      if (idx < int'(v.n) && stall_left == 0) begin
        s_valid = 1'b1;
        s_data  = v.base + 8'(idx * 8'h1D);
        s_last  = (idx == int'(v.n) - 1);
      end else begin
        s_valid = 1'b0; s_last = 1'b0;
        if (stall_left > 0) stall_left--;
      end
      if (!busy && c > 2) begin timed_out = 1'b0; break; end
    end
    s_valid = 1'b0; s_last = 1'b0; start = 1'b0; partial = 1'b0;
    chk(!timed_out, "R10", int'(timed_out), 0);
    chk(err == v.xerr, err_req(v.xerr), int'(err), int'(v.xerr));
    chk(done == (v.xerr == 2'd0), "R8", int'(done), int'(v.xerr == 2'd0));
    chk(seen_busy == !v.partial, "R10", int'(seen_busy), int'(!v.partial));
    if (v.partial || v.stuck)      exp_bits = 0;
    else if (v.good)               exp_bits = 8 * int'(v.n) + ACT_BITS;
    else                           exp_bits = 8 * int'(v.n);
    chk(bits_total - bits_base == exp_bits,
        v.stuck ? "R2" : (v.good ? "R8" : "R7"), bits_total - bits_base, exp_bits);
    if (!v.partial) begin
      chk(rst_low - rst0 >= RST_CYC, "R1", rst_low - rst0, RST_CYC);
      chk(rst_cs_bad - bad0 == 0, "R1", rst_cs_bad - bad0, 0);
    end else begin
      chk(rst_low - rst0 == 0, "R9", rst_low - rst0, 0);
    end
    if (!v.partial && !v.stuck) begin
      chk(hk_cnt - hk0 >= HK_CYC, "R3", hk_cnt - hk0, HK_CYC);
      chk(accepted - acc0 == int'(v.n), "R6", accepted - acc0, int'(v.n));
      for (int b = 0; b < int'(v.n); b++) begin
        automatic logic [7:0] e = v.base + 8'(b * 8'h1D);
        automatic logic [7:0] a = rx[(bits_base / 8 + b) % 64];
        chk(a == e, "R4", int'(a), int'(e));
      end
      chk(hi_bad - hib0 == 0 && hi_pulses - hip0 > 0, "R5",
          hi_bad - hib0, 0);
    end
    if (!v.partial && !v.stuck && v.good) begin
      for (int b = 0; b < 7; b++) begin
        automatic logic [7:0] a = rx[(bits_base / 8 + int'(v.n) + b) % 64];
        chk(a == 8'h00, "R8", int'(a), 0);
      end
    end
    chk(ready_bad - rb0 == 0, "R6", ready_bad - rb0, 0);
    chk(tgt_cs_n && tgt_rst_n && !tgt_sck, "R12",
        int'({tgt_cs_n, tgt_rst_n, tgt_sck}), 3'b110);
    repeat (20) @(negedge clk);
    chk(err == v.xerr, "R11", int'(err), int'(v.xerr));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && err == 2'd0, "R11", int'({busy, done, err}), 0);
    chk(tgt_cs_n && tgt_rst_n && !tgt_sck && !s_ready, "R12",
        int'({tgt_cs_n, tgt_rst_n, tgt_sck, s_ready}), 4'b1100);
    for (int i = 0; i < NV; i++) run_case(VECS[i]);
    // R10: a start arriving while busy must not restart the run
    run_case(VECS[1]);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule